// File: doc/BRIEF.md
# Arithmetic Right Shift Unit with Carry and Condition Flags

This block is one execution slice of a processor core. It decodes two compact 16-bit instruction forms that shift a 32-bit operand arithmetically to the right, then applies the shift. In the register form, the count comes from a second register operand. In the immediate form, the count is a 5-bit field of the instruction word.

The slice returns three things:
- the shifted result;
- a carry flag, which reports whether a negative operand lost any 1 bits off its low end;
- an optional 4-bit condition field, which holds the signed comparison of the result against zero together with the incoming summary-overflow bit.

The block also returns the register indices decoded from the instruction word. The surrounding core uses them to read the register file and to write back the result.

The operands and the instruction word are sampled on an issue strobe. All results appear from a single output register stage, one clock after issue, each with its own write enable. When record is off, the condition field register keeps its old value. A word that matches neither encoding raises an illegal flag and asserts no write enable.

Top module: `ashr_unit`

## Requirements
- R1: The shift count is `cnt_val[5:0]` for the register form and the 5-bit immediate `insn[8:4]`, zero-extended, for the immediate form. Bits 31..6 of `cnt_val` have no effect.
- R2: For counts 0..31, `res_q` is `src_val` shifted right by the count. Bits leaving bit 0 are discarded, and copies of `src_val[31]` fill the vacated upper bits.
- R3: `ca_q` is 1 only when `src_val[31]` is 1 and at least one 1 bit is shifted out below bit 0. Otherwise `ca_q` is 0.
- R4: A count of zero gives `res_q == src_val` and `ca_q == 0`.
- R5: A register-form count of 32..63 gives `res_q` equal to 32 copies of `src_val[31]`, and `ca_q == src_val[31]`.
- R6: With `rec_en` high on a legal issue, `cr_we` is 1 and `cr_q` is {LT, GT, EQ, SO} in bits 3..0. LT, GT and EQ come from the signed comparison of the result with zero, and SO equals `so_in`.
- R7: With `rec_en` low on a legal issue, `cr_we` is 0 and `cr_q` keeps its previous value.
- R8: The register form is `insn[15:8] == 8'b01000001`, with the count register index in `insn[7:4]` and the source/destination index in `insn[3:0]`. The immediate form is `insn[15:9] == 7'b0110101`, with the immediate in `insn[8:4]` and the source/destination index in `insn[3:0]`. The outputs `cnt_idx` and `rx_idx` show those fields combinationally, and `wr_idx` shows the registered destination index.
- R9: An issued word that matches neither form sets `illegal_q` for one cycle and leaves `res_we`, `ca_we` and `cr_we` at 0.
- R10: Results appear one clock after the issue cycle, with `res_we` and `ca_we` set. In a cycle without issue, all write enables and `illegal_q` are 0. After reset, every registered output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | Instruction word and operands are valid this cycle |
| insn | input | 16 | Compact instruction word |
| rec_en | input | 1 | Record enable for the condition field |
| so_in | input | 1 | Incoming summary-overflow bit |
| src_val | input | 32 | Source operand value |
| cnt_val | input | 32 | Count register value (register form) |
| cnt_idx | output | 4 | Decoded count register index |
| rx_idx | output | 4 | Decoded source/destination register index |
| res_q | output | 32 | Shift result |
| res_we | output | 1 | Result write enable |
| ca_q | output | 1 | Carry flag |
| ca_we | output | 1 | Carry write enable |
| cr_q | output | 4 | Condition field {LT,GT,EQ,SO} |
| cr_we | output | 1 | Condition field write enable |
| wr_idx | output | 4 | Registered destination register index |
| illegal_q | output | 1 | Issued word matched neither form |

## Verification
The bench checks the counts 0, 1, 31, 32 and 63. A design that treated 32..63 modulo 32 would return an unshifted or barely shifted value where full sign fill is due. A design that set carry at count zero would report a loss that never happened.

Carry is checked with negative operands whose shifted-out bits are all zero, and with positive operands that drop 1 bits. A design that took carry from the result or ignored the sign would flag these wrongly.

Upper bits of the count register are set on purpose. A design that decoded a wider count would then saturate. The bench also checks that the condition field holds across unrecorded operations, and it issues near-miss opcodes that must assert no write enable.

// File: rtl/ashr_pkg.sv
// Shared constants and types for the arithmetic right shift slice.
// Assumes 16-bit compact instruction words with a 4-bit register index.
package ashr_pkg;
    localparam int INSN_W    = 16;
    localparam int REG_IDX_W = 4;
    localparam int IMM_W     = 5;

    localparam logic [7:0] OPC_REG_FORM = 8'b0100_0001;
    localparam logic [6:0] OPC_IMM_FORM = 7'b011_0101;

    typedef enum logic [1:0] {
        FORM_NONE = 2'd0,
        FORM_REG  = 2'd1,
        FORM_IMM  = 2'd2
    } form_e;
endpackage

// File: rtl/ashr_decode.sv
// Instruction decoder: recognises the two compact shift forms, picks the
// shift count source and extracts the register index fields.
// Assumes CNT_W is wide enough to hold the zero-extended immediate.
module ashr_decode
    import ashr_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [INSN_W-1:0]    insn,
    input  logic [CNT_W-1:0]     cnt_low,
    output form_e                form,
    output logic [CNT_W-1:0]     cnt,
    output logic [REG_IDX_W-1:0] cnt_idx,
    output logic [REG_IDX_W-1:0] rx_idx
);
    localparam int IMM_LSB = REG_IDX_W;

    // Purpose: match the opcode and select the count for the matched form.
    always_comb begin
        cnt_idx = insn[2*REG_IDX_W-1:REG_IDX_W];
        rx_idx  = insn[REG_IDX_W-1:0];
        if (insn[INSN_W-1:INSN_W-8] == OPC_REG_FORM) begin
            form = FORM_REG;
            cnt  = cnt_low;
        end else if (insn[INSN_W-1:INSN_W-7] == OPC_IMM_FORM) begin
            form = FORM_IMM;
            cnt  = CNT_W'(insn[IMM_LSB+IMM_W-1:IMM_LSB]);
        end else begin
            form = FORM_NONE;
            cnt  = '0;
        end
    end
endmodule

// File: rtl/ashr_shift_core.sv
// Arithmetic right shift datapath with lost-bit carry.
// Counts of W and above saturate to full sign fill; carry is the sign
// ANDed with the OR of the bits that fall below bit 0.
module ashr_shift_core #(
    parameter int W     = 32,
    parameter int CNT_W = 6
) (
    input  logic [W-1:0]     src,
    input  logic [CNT_W-1:0] cnt,
    output logic [W-1:0]     res,
    output logic             ca
);
    localparam int SH_W = CNT_W - 1;

    logic                sign;
    logic                sat;
    logic [W-1:0]        lost_mask;
    logic signed [W-1:0] shifted;

    assign sign = src[W-1];
    assign sat  = (cnt >= CNT_W'(W));

    // Purpose: mark each source bit that leaves the word for this count.
    for (genvar i = 0; i < W; i++) begin : g_lost
        assign lost_mask[i] = sat | (CNT_W'(i) < cnt);
    end

    assign shifted = $signed(src) >>> cnt[SH_W-1:0];

    // Purpose: choose saturated sign fill or the in-range shift, and form carry.
    always_comb begin
        res = sat ? {W{sign}} : shifted;
        ca  = sign & (|(src & lost_mask));
    end
endmodule

// File: rtl/ashr_flags.sv
// Condition field builder: signed compare of the result with zero plus SO.
// Layout is {LT, GT, EQ, SO} from the top bit down.
module ashr_flags #(
    parameter int W = 32
) (
    input  logic [W-1:0] res,
    input  logic         so,
    output logic [3:0]   cr
);
    logic lt, gt, eq;

    // Purpose: derive exactly one of LT/GT/EQ from the result.
    always_comb begin
        lt = res[W-1];
        eq = (res == '0);
        gt = ~lt & ~eq;
        cr = {lt, gt, eq, so};
    end
endmodule

// File: rtl/ashr_unit.sv
// Top of the arithmetic right shift slice. Decodes the compact word,
// shifts, builds flags and registers everything one cycle after issue.
// Assumes operands are presented in the same cycle as issue.
module ashr_unit
    import ashr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue,
    input  logic [INSN_W-1:0]    insn,
    input  logic                 rec_en,
    input  logic                 so_in,
    input  logic [W-1:0]         src_val,
    input  logic [W-1:0]         cnt_val,
    output logic [REG_IDX_W-1:0] cnt_idx,
    output logic [REG_IDX_W-1:0] rx_idx,
    output logic [W-1:0]         res_q,
    output logic                 res_we,
    output logic                 ca_q,
    output logic                 ca_we,
    output logic [3:0]           cr_q,
    output logic                 cr_we,
    output logic [REG_IDX_W-1:0] wr_idx,
    output logic                 illegal_q
);
    localparam int CNT_W = $clog2(W) + 1;

    form_e            form;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     res_d;
    logic             ca_d;
    logic [3:0]       cr_d;
    logic             legal;
    logic             unused_cnt_hi;

    assign unused_cnt_hi = ^cnt_val[W-1:CNT_W];

    ashr_decode #(.CNT_W(CNT_W)) u_dec (
        .insn    (insn),
        .cnt_low (cnt_val[CNT_W-1:0]),
        .form    (form),
        .cnt     (cnt),
        .cnt_idx (cnt_idx),
        .rx_idx  (rx_idx)
    );

    ashr_shift_core #(.W(W), .CNT_W(CNT_W)) u_core (
        .src (src_val),
        .cnt (cnt),
        .res (res_d),
        .ca  (ca_d)
    );

    ashr_flags #(.W(W)) u_flags (
        .res (res_d),
        .so  (so_in),
        .cr  (cr_d)
    );

    assign legal = (form != FORM_NONE);

    // Purpose: output stage with write enables; the condition field holds
    // unless recorded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q     <= '0;
            res_we    <= 1'b0;
            ca_q      <= 1'b0;
            ca_we     <= 1'b0;
            cr_q      <= '0;
            cr_we     <= 1'b0;
            wr_idx    <= '0;
            illegal_q <= 1'b0;
        end else begin
            res_we    <= issue & legal;
            ca_we     <= issue & legal;
            cr_we     <= issue & legal & rec_en;
            illegal_q <= issue & ~legal;
            if (issue && legal) begin
                res_q  <= res_d;
                ca_q   <= ca_d;
                wr_idx <= rx_idx;
                if (rec_en) cr_q <= cr_d;
            end
        end
    end

    // R4: zero count passes the source and clears carry.
    p_zero_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && legal && cnt == '0) |=> (res_q == $past(src_val) && !ca_q));

    // R5: register count of W and above fills with the sign, carry = sign.
    p_sat_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && form == FORM_REG && cnt[CNT_W-1])
        |=> (res_q == {W{$past(src_val[W-1])}} && ca_q == $past(src_val[W-1])));

    // R2: the result keeps the source sign.
    p_sign_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && legal) |=> (res_q[W-1] == $past(src_val[W-1])));

    // R3: carry only ever comes from a negative operand.
    p_carry_neg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ca_we && ca_q) |-> res_q[W-1]);

    // R6: a recorded field has exactly one compare bit set.
    p_cr_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> ($countones(cr_q[3:1]) == 1));

    // R7: without a write, the condition field is stable.
    p_cr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cr_we |-> $stable(cr_q));

    // R9: an illegal word writes nothing.
    p_illegal_no_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |-> (!res_we && !ca_we && !cr_we));
endmodule

// File: tb/tb_ashr_unit.sv
module tb_ashr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [15:0] insn = '0;
    logic        rec_en = 1'b0;
    logic        so_in = 1'b0;
    logic [31:0] src_val = '0;
    logic [31:0] cnt_val = '0;
    logic [3:0]  cnt_idx, rx_idx, wr_idx;
    logic [31:0] res_q;
    logic        res_we, ca_q, ca_we, cr_we, illegal_q;
    logic [3:0]  cr_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ashr_unit dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .insn(insn), .rec_en(rec_en),
        .so_in(so_in), .src_val(src_val), .cnt_val(cnt_val), .cnt_idx(cnt_idx),
        .rx_idx(rx_idx), .res_q(res_q), .res_we(res_we), .ca_q(ca_q),
        .ca_we(ca_we), .cr_q(cr_q), .cr_we(cr_we), .wr_idx(wr_idx),
        .illegal_q(illegal_q)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] enc_reg(input logic [3:0] ry, input logic [3:0] rx);
        return {8'b0100_0001, ry, rx};
    endfunction

    function automatic logic [15:0] enc_imm(input logic [4:0] imm, input logic [3:0] rx);
        return {7'b011_0101, imm, rx};
    endfunction

    function automatic logic [31:0] ref_res(input logic [31:0] s, input int n);
        int nn = (n > 31) ? 31 : n;
        return $signed(s) >>> nn;
    endfunction

    function automatic logic ref_ca(input logic [31:0] s, input int n);
        if (n == 0) return 1'b0;
        if (n >= 32) return s[31];
        return s[31] & (|(s & ((32'h1 << n) - 32'h1)));
    endfunction

    function automatic logic [3:0] ref_cr(input logic [31:0] r, input logic so);
        logic lt = r[31];
        logic eq = (r == 32'h0);
        return {lt, ~lt & ~eq, eq, so};
    endfunction

    task automatic do_op(input logic [15:0] w, input logic [31:0] s, input logic [31:0] c,
                         input logic rec, input logic so);
        @(negedge clk);
        issue = 1'b1; insn = w; src_val = s; cnt_val = c; rec_en = rec; so_in = so;
        @(posedge clk);
        #1;
        issue = 1'b0;
    endtask

    task automatic run_op(input string tag, input logic [15:0] w, input logic [31:0] s,
                          input logic [31:0] c, input int n, input logic rec, input logic so);
        logic [31:0] er;
        do_op(w, s, c, rec, so);
        er = ref_res(s, n);
        chk({tag, " R2 result"}, res_q, er);
        chk({tag, " R3 carry"}, 32'(ca_q), 32'(ref_ca(s, n)));
        chk({tag, " R10 we"}, {29'b0, res_we, ca_we, illegal_q}, 32'b110);
        if (rec) chk({tag, " R6 cr"}, {27'b0, cr_we, cr_q}, {27'b0, 1'b1, ref_cr(er, so)});
    endtask

    task automatic t_reset();
        chk("R10 reset res", res_q, 32'h0);
        chk("R10 reset flags", {24'b0, res_we, ca_we, ca_q, cr_we, cr_q}, 32'h0);
        chk("R10 reset misc", {27'b0, wr_idx, illegal_q}, 32'h0);
    endtask

    task automatic t_zero();
        run_op("R4 reg zero neg", enc_reg(4'd2, 4'd5), 32'h8000_0001, 32'h0, 0, 1'b0, 1'b0);
        run_op("R4 imm zero", enc_imm(5'd0, 4'd5), 32'hDEAD_BEEF, 32'hFFFF_FFFF, 0, 1'b0, 1'b0);
    endtask

    task automatic t_reg_counts();
        int cl[5] = '{0, 1, 31, 32, 63};
        foreach (cl[k]) begin
            run_op("R5 reg neg", enc_reg(4'd1, 4'd2), 32'hF000_0003, 32'(cl[k]), cl[k], 1'b0, 1'b0);
            run_op("R5 reg pos", enc_reg(4'd1, 4'd2), 32'h7000_0003, 32'(cl[k]), cl[k], 1'b0, 1'b0);
            run_op("R5 reg negtail0", enc_reg(4'd1, 4'd2), 32'h8000_0000, 32'(cl[k]), cl[k], 1'b0, 1'b0);
        end
        run_op("R1 upper cnt bits", enc_reg(4'd3, 4'd4), 32'h8000_0001, 32'hFFFF_FFC1, 1, 1'b0, 1'b0);
        run_op("R1 upper cnt 32", enc_reg(4'd3, 4'd4), 32'h8000_0000, 32'h1234_5660, 32, 1'b0, 1'b0);
    endtask

    task automatic t_imm_counts();
        int cl[3] = '{1, 16, 31};
        foreach (cl[k]) begin
            run_op("R1 imm", enc_imm(5'(cl[k]), 4'd7), 32'h9234_5679, 32'h0000_0020, cl[k], 1'b0, 1'b0);
            run_op("R3 imm neg clean", enc_imm(5'(cl[k]), 4'd7), 32'h8000_0000, 32'h0, cl[k], 1'b0, 1'b0);
        end
    endtask

    task automatic t_random();
        for (int i = 0; i < 300; i++) begin
            logic [31:0] s = $urandom;
            logic [31:0] c = $urandom;
            logic [4:0]  im = 5'($urandom);
            if (i % 2 == 0)
                run_op("R2 rand reg", enc_reg(4'(i), 4'(i + 1)), s, c, int'(c[5:0]), i[2], i[3]);
            else
                run_op("R2 rand imm", enc_imm(im, 4'(i)), s, c, int'(im), i[2], i[3]);
        end
    endtask

    task automatic t_record();
        run_op("R6 neg", enc_imm(5'd1, 4'd1), 32'h8000_0000, 32'h0, 1, 1'b1, 1'b1);
        run_op("R6 pos", enc_imm(5'd1, 4'd1), 32'h0000_0100, 32'h0, 1, 1'b1, 1'b0);
        run_op("R6 zero", enc_reg(4'd0, 4'd1), 32'h0000_0001, 32'd5, 5, 1'b1, 1'b1);
    endtask

    task automatic t_hold();
        logic [3:0] prev;
        run_op("R7 setup", enc_imm(5'd0, 4'd1), 32'hFFFF_0000, 32'h0, 0, 1'b1, 1'b0);
        prev = cr_q;
        do_op(enc_imm(5'd4, 4'd1), 32'h0000_0000, 32'h0, 1'b0, 1'b1);
        chk("R7 cr_we low", 32'(cr_we), 32'h0);
        chk("R7 cr held", 32'(cr_q), 32'(prev));
        chk("R7 result still written", res_q, 32'h0);
    endtask

    task automatic t_illegal();
        logic [15:0] bad[3] = '{16'hFFFF, 16'h4012, 16'h6812};
        foreach (bad[k]) begin
            do_op(bad[k], 32'h8000_00FF, 32'd4, 1'b1, 1'b1);
            chk("R9 illegal", {28'b0, illegal_q, res_we, ca_we, cr_we}, 32'b1000);
        end
    endtask

    task automatic t_decode();
        @(negedge clk);
        insn = enc_reg(4'hA, 4'h6);
        #1;
        chk("R8 reg idx", {24'b0, cnt_idx, rx_idx}, 32'hA6);
        insn = enc_imm(5'd9, 4'hC);
        #1;
        chk("R8 imm rx", 32'(rx_idx), 32'hC);
        do_op(enc_reg(4'h3, 4'hE), 32'h10, 32'd1, 1'b0, 1'b0);
        chk("R8 wr_idx", 32'(wr_idx), 32'hE);
        @(posedge clk);
        #1;
        chk("R10 idle we", {29'b0, res_we, cr_we, illegal_q}, 32'h0);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_zero();
        t_reg_counts();
        t_imm_counts();
        t_record();
        t_hold();
        t_illegal();
        t_decode();
        t_random();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule